// File: doc/BRIEF.md
# Four-Way Set-Associative Cache Read Lookup

This block is the read side of a 4-way set-associative cache with 64 sets and 16-byte lines. A CPU pipeline presents a read address and an access size in its execute stage. The block registers the request, and in the next stage it compares the four stored tags of the selected set in parallel. It then returns the requested byte, halfword or longword, right-aligned and zero-extended, together with hit, multi-hit and alignment-error flags. A new request can be accepted on every cycle, so a run of hits streams with no wait states.

A fill port writes a whole line into one chosen way of one set in a single cycle, storing its tag and marking it valid. A synchronous invalidate-all input clears every valid bit. A stall input freezes the lookup stage, so a result that has not yet been consumed stays on the outputs.

Top module: `cache_rd_path`

## Requirements
- R1: The address is split into a byte offset in bits [3:0], a set index in bits [9:4] and a tag in bits [31:10]. A hit is reported when a valid way of the indexed set holds a tag equal to the address tag.
- R2: A way whose valid bit is clear never matches, whatever tag it holds.
- R3: A request accepted at a rising edge (req_valid high, stall low) appears on the rsp_* outputs right after that edge, with rsp_valid high. When no request was accepted, rsp_valid is low and rsp_hit and rsp_align_err are low.
- R4: Requests may be accepted on consecutive cycles. Each one produces its own response in the following cycle, in order, with none lost or repeated.
- R5: Line byte i is fill_line[8i+7:8i]. A byte access (size code 0) returns the byte at the offset in rsp_data[7:0], with the upper bits zero.
- R6: A halfword access (size code 1) at an even offset o returns {byte o+1, byte o} in rsp_data[15:0], with the upper bits zero.
- R7: A longword access (size code 2) at an offset that is a multiple of 4 returns {byte o+3, byte o+2, byte o+1, byte o}.
- R8: A halfword at an odd offset, a longword at an offset that is not a multiple of 4, or size code 3 sets rsp_align_err. It also forces rsp_hit and rsp_multi_hit low and rsp_data to zero.
- R9: On a miss, rsp_hit is low and rsp_data is zero.
- R10: When more than one valid way matches, rsp_multi_hit and rsp_hit are both high, and the data comes from the lowest-numbered matching way.
- R11: A fill (fill_en high) writes fill_line, fill_tag and a set valid bit into way fill_way of set fill_idx. It replaces whatever that way held before.
- R12: inv_all clears every valid bit at the next edge. It takes priority over a fill in the same cycle, so that fill leaves nothing valid.
- R13: While stall is high, the lookup stage holds its request and the incoming request is ignored. The response stays unchanged until stall falls.
- R14: Synchronous active-low reset clears rsp_valid and all valid bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall | input | 1 | Freezes the lookup stage |
| req_valid | input | 1 | Read request present |
| req_addr | input | 32 | Read byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 longword, 3 reserved |
| fill_en | input | 1 | Write a line this cycle |
| fill_idx | input | 6 | Set to fill |
| fill_way | input | 2 | Way to fill |
| fill_tag | input | 22 | Tag stored with the line |
| fill_line | input | 128 | Line data, byte i at bits 8i+7:8i |
| inv_all | input | 1 | Clear all valid bits |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Aligned access matched a valid way |
| rsp_multi_hit | output | 1 | More than one valid way matched |
| rsp_align_err | output | 1 | Misaligned or reserved-size access |
| rsp_data | output | 32 | Right-aligned zero-extended read data |

## Verification
A corrupt valid or tag bit shows up on the very next read of that set, as a wrong rsp_hit or as data from the wrong way. The scoreboard compares every response in the cycle it appears. A wrong byte-lane selection shows up only for the offsets and sizes that use those lanes, so reads sweep every longword position and the edge offsets for bytes and halfwords. A broken stall hold or lost pipeline state shows up one cycle later, as a changed or missing response.

// File: rtl/cache_rd_pkg.sv
// Shared types and geometry for the cache read lookup path.
// Assumes a byte-addressed bus with power-of-two line and set counts.
package cache_rd_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    localparam int DATA_W = 32;
endpackage

// File: rtl/crp_tag_store.sv
// Per-set, per-way tags and valid bits. Fill writes one way; invalidate-all
// clears every valid bit and overrides a fill in the same cycle.
// Assumes read index is stable during the cycle it is used (registered upstream).
module crp_tag_store #(
    parameter int SETS  = 64,
    parameter int WAYS  = 4,
    parameter int TAG_W = 22,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        inv_all,
    input  logic                        fill_en,
    input  logic [IDX_W-1:0]            fill_idx,
    input  logic [WAY_W-1:0]            fill_way,
    input  logic [TAG_W-1:0]            fill_tag,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [WAYS-1:0]             rd_valid,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tags
);
    logic [WAYS-1:0]            valid_q [SETS];
    logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];

    // Valid bits: cleared by reset or invalidate-all, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n || inv_all) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else if (fill_en) begin
            valid_q[fill_idx][fill_way] <= 1'b1;
        end
    end

    // Tag storage: written on fill, no reset needed behind the valid bits.
    always_ff @(posedge clk) begin
        if (fill_en) tag_q[fill_idx][fill_way] <= fill_tag;
    end

    // Combinational read of the indexed set.
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_tags  = tag_q[rd_idx];
    end

    // R12
    inv_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (rd_valid == '0));
endmodule

// File: rtl/crp_line_store.sv
// Line data storage, one full line per set and way, written whole on fill.
// Assumes reads of a set being filled in the same cycle see the old line.
module crp_line_store #(
    parameter int SETS      = 64,
    parameter int WAYS      = 4,
    parameter int LINE_BITS = 128,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                            clk,
    input  logic                            fill_en,
    input  logic [IDX_W-1:0]                fill_idx,
    input  logic [WAY_W-1:0]                fill_way,
    input  logic [LINE_BITS-1:0]            fill_line,
    input  logic [IDX_W-1:0]                rd_idx,
    output logic [WAYS-1:0][LINE_BITS-1:0]  rd_lines
);
    logic [WAYS-1:0][LINE_BITS-1:0] line_q [SETS];

    // Whole-line write from the fill port.
    always_ff @(posedge clk) begin
        if (fill_en) line_q[fill_idx][fill_way] <= fill_line;
    end

    // Combinational read of every way of the indexed set.
    always_comb rd_lines = line_q[rd_idx];
endmodule

// File: rtl/crp_way_match.sv
// Parallel tag compare across all ways; picks the lowest-numbered match and
// flags more than one match. Assumes rd_valid gates every way.
module crp_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 22,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             way_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]  way_tags,
    input  logic [TAG_W-1:0]            look_tag,
    output logic                        any_hit,
    output logic                        multi_hit,
    output logic [WAY_W-1:0]            sel_way
);
    logic [WAYS-1:0] match;

    // One comparator per way, qualified by its valid bit.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = way_valid[w] && (way_tags[w] == look_tag);
    end

    // Lowest-index priority select and match counting.
    always_comb begin
        sel_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) sel_way = WAY_W'(w);
        end
        any_hit   = |match;
        multi_hit = ($countones(match) > 1);
    end
endmodule

// File: rtl/crp_align.sv
// Extracts a byte, halfword or longword from a line at a byte offset,
// right-aligned and zero-extended, and flags misaligned or reserved sizes.
// Assumes little-endian byte order within the line.
module crp_align
    import cache_rd_pkg::*;
#(
    parameter int OFF_W = 4,
    localparam int LINE_BITS = 8 << OFF_W
) (
    input  logic [LINE_BITS-1:0] line,
    input  logic [OFF_W-1:0]     off,
    input  size_e                size,
    output logic [DATA_W-1:0]    data,
    output logic                 misaligned
);
    logic [LINE_BITS-1:0] shifted;

    // Shift the addressed byte down to lane 0, then mask by size.
    always_comb begin
        shifted = line >> {off, 3'b000};
        unique case (size)
            SZ_BYTE: data = {24'b0, shifted[7:0]};
            SZ_HALF: data = {16'b0, shifted[15:0]};
            default: data = shifted[DATA_W-1:0];
        endcase
    end

    // Alignment rule per size; the reserved code always errors.
    always_comb begin
        unique case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = off[0];
            SZ_WORD: misaligned = |off[1:0];
            default: misaligned = 1'b1;
        endcase
    end
endmodule

// File: rtl/cache_rd_path.sv
// Two-stage cache read lookup. Stage 1 registers the request; stage 2 reads
// tags and lines of the indexed set, compares, aligns and drives the result.
// Assumes the consumer samples rsp_* in the cycle after acceptance; stall
// freezes the stage-2 request so its result is held.
module cache_rd_path
    import cache_rd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 4,
    parameter int IDX_W  = 6,
    parameter int WAYS   = 4,
    localparam int TAG_W     = ADDR_W - IDX_W - OFF_W,
    localparam int SETS      = 1 << IDX_W,
    localparam int LINE_BITS = 8 << OFF_W,
    localparam int WAY_W     = $clog2(WAYS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stall,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [1:0]           req_size,
    input  logic                 fill_en,
    input  logic [IDX_W-1:0]     fill_idx,
    input  logic [WAY_W-1:0]     fill_way,
    input  logic [TAG_W-1:0]     fill_tag,
    input  logic [LINE_BITS-1:0] fill_line,
    input  logic                 inv_all,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic                 rsp_multi_hit,
    output logic                 rsp_align_err,
    output logic [DATA_W-1:0]    rsp_data
);
    logic                           s2_vld;
    logic [ADDR_W-1:0]              s2_addr;
    size_e                          s2_size;
    logic [OFF_W-1:0]               s2_off;
    logic [IDX_W-1:0]               s2_idx;
    logic [TAG_W-1:0]               s2_tag;
    logic [WAYS-1:0]                set_valid;
    logic [WAYS-1:0][TAG_W-1:0]     set_tags;
    logic [WAYS-1:0][LINE_BITS-1:0] set_lines;
    logic                           any_hit;
    logic                           multi_hit;
    logic [WAY_W-1:0]               sel_way;
    logic [DATA_W-1:0]              aligned;
    logic                           misaligned;

    // Stage register between execute and memory-access; frozen by stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_vld  <= 1'b0;
            s2_addr <= '0;
            s2_size <= SZ_BYTE;
        end else if (!stall) begin
            s2_vld  <= req_valid;
            s2_addr <= req_addr;
            s2_size <= size_e'(req_size);
        end
    end

    // Address field split for the lookup stage.
    always_comb begin
        s2_off = s2_addr[OFF_W-1:0];
        s2_idx = s2_addr[OFF_W +: IDX_W];
        s2_tag = s2_addr[ADDR_W-1 -: TAG_W];
    end

    crp_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .inv_all  (inv_all),
        .fill_en  (fill_en),
        .fill_idx (fill_idx),
        .fill_way (fill_way),
        .fill_tag (fill_tag),
        .rd_idx   (s2_idx),
        .rd_valid (set_valid),
        .rd_tags  (set_tags)
    );

    crp_line_store #(.SETS(SETS), .WAYS(WAYS), .LINE_BITS(LINE_BITS)) u_lines (
        .clk       (clk),
        .fill_en   (fill_en),
        .fill_idx  (fill_idx),
        .fill_way  (fill_way),
        .fill_line (fill_line),
        .rd_idx    (s2_idx),
        .rd_lines  (set_lines)
    );

    crp_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .way_valid (set_valid),
        .way_tags  (set_tags),
        .look_tag  (s2_tag),
        .any_hit   (any_hit),
        .multi_hit (multi_hit),
        .sel_way   (sel_way)
    );

    crp_align #(.OFF_W(OFF_W)) u_align (
        .line       (set_lines[sel_way]),
        .off        (s2_off),
        .size       (s2_size),
        .data       (aligned),
        .misaligned (misaligned)
    );

    // Response assembly: alignment errors suppress hit and data.
    always_comb begin
        rsp_valid     = s2_vld;
        rsp_align_err = s2_vld && misaligned;
        rsp_hit       = s2_vld && !misaligned && any_hit;
        rsp_multi_hit = rsp_hit && multi_hit;
        rsp_data      = rsp_hit ? aligned : '0;
    end

    // R10
    multi_implies_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_multi_hit |-> rsp_hit);

    // R8
    align_blocks_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_align_err |-> (!rsp_hit && rsp_data == '0));

    // R4
    pipe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(stall)) |-> (rsp_valid == $past(req_valid)));

    // R13
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(stall) && !$past(fill_en) && !$past(inv_all))
        |-> ($stable(rsp_valid) && $stable(rsp_hit) && $stable(rsp_data)));
endmodule

// File: tb/cache_rd_path_tb.sv
`timescale 1ns/1ps
module cache_rd_path_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         stall = 1'b0;
    logic         req_valid = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [1:0]   req_size = '0;
    logic         fill_en = 1'b0;
    logic [5:0]   fill_idx = '0;
    logic [1:0]   fill_way = '0;
    logic [21:0]  fill_tag = '0;
    logic [127:0] fill_line = '0;
    logic         inv_all = 1'b0;
    logic         rsp_valid, rsp_hit, rsp_multi_hit, rsp_align_err;
    logic [31:0]  rsp_data;

    always #2.5 clk = ~clk;

    cache_rd_path u_dut (
        .clk(clk), .rst_n(rst_n), .stall(stall), .req_valid(req_valid),
        .req_addr(req_addr), .req_size(req_size), .fill_en(fill_en),
        .fill_idx(fill_idx), .fill_way(fill_way), .fill_tag(fill_tag),
        .fill_line(fill_line), .inv_all(inv_all), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_multi_hit(rsp_multi_hit),
        .rsp_align_err(rsp_align_err), .rsp_data(rsp_data)
    );

    typedef struct {
        logic        hit;
        logic        multi;
        logic        err;
        logic [31:0] data;
        string       req;
    } exp_t;

    exp_t         q[$];
    exp_t         last;
    bit           have_last = 0;
    bit           mon_on = 0;
    bit           done = 0;
    logic         stall_edge = 1'b0;
    int           n_run = 0;
    int           n_fail = 0;

    logic         m_valid [64][4];
    logic [21:0]  m_tag   [64][4];
    logic [127:0] m_line  [64][4];

    function automatic exp_t model(logic [31:0] a, logic [1:0] sz, string r);
        exp_t e;
        int o = int'(a[3:0]);
        int ix = int'(a[9:4]);
        int cnt = 0;
        int low = -1;
        int nb;
        e.req = r; e.hit = 0; e.multi = 0; e.err = 0; e.data = '0;
        if (sz == 2'd3 || (sz == 2'd1 && a[0]) || (sz == 2'd2 && a[1:0] != 2'b00)) begin
            e.err = 1;
            return e;
        end
        for (int w = 0; w < 4; w++) begin
            if (m_valid[ix][w] && m_tag[ix][w] == a[31:10]) begin
                cnt++;
                if (low < 0) low = w;
            end
        end
        if (cnt == 0) return e;
        e.hit = 1;
        e.multi = (cnt > 1);
        nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        for (int j = 0; j < nb; j++) e.data[8*j +: 8] = m_line[ix][low][8*(o+j) +: 8];
        return e;
    endfunction

    function automatic logic [127:0] pat(int ix, int w, int salt);
        logic [127:0] l;
        for (int b = 0; b < 16; b++) l[8*b +: 8] = 8'((ix * 4 + w) * 7 + b * 13 + salt + 1);
        return l;
    endfunction

    task automatic rd(logic [31:0] a, logic [1:0] sz, string r);
        req_valid = 1'b1; req_addr = a; req_size = sz;
        q.push_back(model(a, sz, r));
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic fill(int ix, int w, logic [21:0] t, logic [127:0] l);
        fill_en = 1'b1; fill_idx = 6'(ix); fill_way = 2'(w); fill_tag = t; fill_line = l;
        m_valid[ix][w] = 1'b1; m_tag[ix][w] = t; m_line[ix][w] = l;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic inval(bit with_fill);
        inv_all = 1'b1;
        if (with_fill) begin
            fill_en = 1'b1; fill_idx = 6'd20; fill_way = 2'd0; fill_tag = 22'h2AAAA;
            fill_line = pat(20, 0, 9);
        end
        for (int s = 0; s < 64; s++) for (int w = 0; w < 4; w++) m_valid[s][w] = 1'b0;
        @(negedge clk);
        inv_all = 1'b0; fill_en = 1'b0;
    endtask

    task automatic stall_for(int n);
        stall = 1'b1; req_valid = 1'b1; req_addr = 32'hFFFF_FFF0; req_size = 2'd2;
        repeat (n) @(negedge clk);
        stall = 1'b0; req_valid = 1'b0;
    endtask

    function automatic logic [31:0] mk(logic [21:0] t, int ix, int o);
        return {t, 6'(ix), 4'(o)};
    endfunction

    task automatic cmp(exp_t e, string r);
        n_run++;
        if (rsp_hit !== e.hit || rsp_multi_hit !== e.multi || rsp_align_err !== e.err ||
            rsp_data !== e.data) begin
            n_fail++;
            $display("FAIL %s: got hit=%0b multi=%0b err=%0b data=%08h exp hit=%0b multi=%0b err=%0b data=%08h",
                     r, rsp_hit, rsp_multi_hit, rsp_align_err, rsp_data,
                     e.hit, e.multi, e.err, e.data);
        end
    endtask

    always @(posedge clk) stall_edge <= stall;

    // Monitor: pops the scoreboard as responses appear; checks held ones.
    always @(negedge clk) begin
        if (mon_on && rsp_valid) begin
            if (stall_edge && have_last) begin
                cmp(last, "R13 held");
            end else if (q.size() == 0) begin
                n_run++; n_fail++;
                $display("FAIL R3: unexpected response data=%08h exp none", rsp_data);
            end else begin
                last = q.pop_front();
                have_last = 1;
                cmp(last, last.req);
            end
        end else if (mon_on) begin
            have_last = 0;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 64; s++) for (int w = 0; w < 4; w++) begin
            m_valid[s][w] = 1'b0; m_tag[s][w] = '0; m_line[s][w] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R14: reset state
        n_run++;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0) begin
            n_fail++;
            $display("FAIL R14: got valid=%0b hit=%0b exp 0 0", rsp_valid, rsp_hit);
        end
        mon_on = 1;
        rd(mk(22'h0, 5, 0), 2'd2, "R14 miss after reset");
        fill(5, 0, 22'h00111, pat(5, 0, 0));
        fill(5, 1, 22'h00222, pat(5, 1, 0));
        fill(5, 2, 22'h00333, pat(5, 2, 0));
        fill(5, 3, 22'h3FFFF, pat(5, 3, 0));
        fill(63, 2, 22'h00000, pat(63, 2, 0));
        fill(10, 1, 22'h01234, pat(10, 1, 0));
        fill(10, 3, 22'h01234, pat(10, 3, 0));
        // R1 R4 R7: back-to-back longwords across ways and offsets
        rd(mk(22'h00111, 5, 0), 2'd2, "R7 way0 off0");
        rd(mk(22'h00222, 5, 4), 2'd2, "R1 R4 way1 off4");
        rd(mk(22'h00333, 5, 8), 2'd2, "R7 way2 off8");
        rd(mk(22'h3FFFF, 5, 12), 2'd2, "R7 way3 off12");
        // R6 halfwords
        rd(mk(22'h00222, 5, 2), 2'd1, "R6 half off2");
        rd(mk(22'h00333, 5, 14), 2'd1, "R6 half off14");
        // R5 bytes
        rd(mk(22'h00111, 5, 1), 2'd0, "R5 byte off1");
        rd(mk(22'h3FFFF, 5, 15), 2'd0, "R5 byte off15");
        // R8 misaligned
        rd(mk(22'h00111, 5, 3), 2'd1, "R8 half odd");
        rd(mk(22'h00111, 5, 2), 2'd2, "R8 word off2");
        rd(mk(22'h00111, 5, 0), 2'd3, "R8 size3");
        // R9 miss, R2 invalid ways with matching reset tag
        rd(mk(22'h00444, 5, 0), 2'd2, "R9 miss");
        rd(mk(22'h00000, 63, 4), 2'd2, "R2 invalid ways");
        rd(mk(22'h00000, 62, 4), 2'd2, "R2 empty set");
        // R10 multi-hit, lowest way
        rd(mk(22'h01234, 10, 8), 2'd2, "R10 multi");
        @(negedge clk);
        // R13 stall holds
        rd(mk(22'h00222, 5, 12), 2'd2, "R13 before stall");
        stall_for(3);
        rd(mk(22'h00333, 5, 4), 2'd2, "R13 after stall");
        // R11 refill replaces way 0
        fill(5, 0, 22'h00555, pat(5, 0, 3));
        rd(mk(22'h00111, 5, 0), 2'd2, "R11 old tag gone");
        rd(mk(22'h00555, 5, 4), 2'd2, "R11 new line");
        // R12 invalidate with simultaneous fill
        inval(1'b1);
        rd(mk(22'h00222, 5, 0), 2'd2, "R12 cleared");
        rd(mk(22'h2AAAA, 20, 0), 2'd2, "R12 fill suppressed");
        repeat (3) @(negedge clk);
        // R4: nothing lost
        n_run++;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R4: got %0d pending exp 0", q.size());
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule